// File: doc/BRIEF.md
# Paged MDIO Management Slave

This block is the target side of a two-wire serial management link. It watches a management clock and a bidirectional data line, both sampled by a faster system clock. It decodes read and write frames sent to its own station address and gives them access to a window of 32 sixteen-bit registers. The window is paged. Address 31 is a page-select register that every page can reach. The other 31 addresses reach the storage of whichever page address 31 currently selects, and page 0 holds the standard set.

A frame may be preceded by any number of idle ones, including none. The slave finds a frame by its start pattern and does not count preamble bits. The frame is start `01`, then a two-bit opcode (`10` read, `01` write), a 5-bit station address, a 5-bit register address, two turnaround bits and 16 data bits. Every field is sent MSB first. The slave samples on each detected rising edge of the management clock and changes what it drives on each detected falling edge. This lets the master sample stable data on the next rising edge. The system clock must run at least four times faster than the management clock.

FSM states: `S_IDLE` (hunting for the first start bit, 0), `S_START` (waiting for the 1 that ends the start pattern), `S_OP`, `S_PHY`, `S_REG` (shifting in fields), `S_TA` (turnaround), `S_RDATA` (driving read data), `S_WDATA` (collecting write data), `S_SKIP` (letting a foreign or invalid frame run out). Transitions, each taken on a detected rising edge:
- `S_IDLE`→`S_START` on a 0.
- `S_START`→`S_OP` on a 1.
- `S_OP`→`S_PHY` after 2 bits.
- `S_PHY`→`S_REG` after 5 bits.
- `S_REG`→`S_TA` after 5 bits when the station address matches and the opcode is valid; otherwise `S_REG`→`S_SKIP`.
- `S_TA`→`S_RDATA` or `S_TA`→`S_WDATA` after 2 bits, depending on the opcode.
- `S_RDATA`/`S_WDATA`→`S_IDLE` after 16 bits.
- `S_SKIP`→`S_IDLE` after 18 bits.

Top module: `mdio_paged_slave`

## Requirements
- R1: After reset the data line is released (output enable 0), every paged register reads 0 and the page-select register reads 0.
- R2: A write frame (opcode `01`) to the own station address stores its 16 data bits, MSB first, in the addressed register of the currently selected page.
- R3: On a read frame (opcode `10`) to the own station address, the slave releases the line for the first turnaround bit and drives 0 for the second. It then drives the 16 data bits MSB first and releases the line again after the last data bit.
- R4: Address 31 holds the page select, and its low log2(NUM_PAGES) bits choose the page. It reads back the written 16-bit value, and reads and writes reach it from every page.
- R5: Addresses 0 to 30 are separate storage in each page, so a write in one page leaves the same address in other pages unchanged.
- R6: A frame whose station address differs from the configured one is ignored: the line is never driven and no register changes.
- R7: The preamble may be any length, including zero. The slave synchronises on the start pattern `01`.
- R8: A frame with opcode `00` or `11` is ignored: the line is never driven and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the management clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_i | input | 1 | Management clock as seen at the pin |
| mdio_i | input | 1 | Data line as seen at the pin |
| phy_addr_i | input | 5 | Configured station address |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_o | output | 1 | Data line output value |

## Verification
A register write and a page change can happen in the same system-clock cycle. This is the case when a write frame targets address 31: the commit strobe that would normally update paged storage must instead update the page select. The write must not also land in the old page's slot 31, and the very next frame must already see the new page. The bench provokes this by writing address 31 from a non-zero page and then reading back address 31 and a paged address on both the old and the new page, comparing against values it has tracked itself. It also sends a frame with no preamble straight after a write. In that case the commit of the finished frame and the start hunt of the next one occur on adjacent management-clock edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int          FIELD_W  = 5;
    localparam logic [1:0]  OP_READ  = 2'b10;
    localparam logic [1:0]  OP_WRITE = 2'b01;
    localparam logic [4:0]  PAGE_ADDR = 5'd31;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_OP,
        S_PHY,
        S_REG,
        S_TA,
        S_RDATA,
        S_WDATA,
        S_SKIP
    } mdio_state_e;

endpackage

// File: rtl/mdc_edge_sync.sv
module mdc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic rise_o,
    output logic fall_o,
    output logic bit_o
);

    logic [SYNC_STAGES-1:0] mdc_q;
    logic [SYNC_STAGES-1:0] dat_q;
    logic                   mdc_prev;

    // both lines pass the same number of stages so a sampled bit lines up with its edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q    <= '0;
            dat_q    <= '1;
            mdc_prev <= 1'b0;
        end else begin
            mdc_q    <= {mdc_q[SYNC_STAGES-2:0], mdc_i};
            dat_q    <= {dat_q[SYNC_STAGES-2:0], mdio_i};
            mdc_prev <= mdc_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = mdc_q[SYNC_STAGES-1] & ~mdc_prev;
    assign fall_o = ~mdc_q[SYNC_STAGES-1] & mdc_prev;
    assign bit_o  = dat_q[SYNC_STAGES-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               bit_i,
    input  logic [FIELD_W-1:0] phy_addr_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               wr_en_o,
    output logic [FIELD_W-1:0] addr_o,
    output logic [DATA_W-1:0]  wr_data_o,
    output logic               oe_o,
    output logic               dout_o,
    output mdio_state_e        state_o,
    output logic [FIELD_W-1:0] phy_o,
    output logic [1:0]         op_o
);

    localparam int CNT_W     = 5;
    localparam int SKIP_BITS = DATA_W + 2;

    mdio_state_e        st, st_n;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-1:0]  sh_q;
    logic [1:0]         op_q;
    logic [FIELD_W-1:0] phy_q;
    logic [FIELD_W-1:0] reg_q;
    logic               is_rd;
    logic               valid_hit;

    assign is_rd     = (op_q == OP_READ);
    assign valid_hit = (phy_q == phy_addr_i) && (op_q == OP_READ || op_q == OP_WRITE);

    always_comb begin
        st_n = st;
        if (rise_i) begin
            unique case (st)
                S_IDLE:  if (!bit_i) st_n = S_START;
                S_START: if (bit_i)  st_n = S_OP;
                S_OP:    if (cnt == CNT_W'(1)) st_n = S_PHY;
                S_PHY:   if (cnt == CNT_W'(FIELD_W-1)) st_n = S_REG;
                S_REG:   if (cnt == CNT_W'(FIELD_W-1)) st_n = valid_hit ? S_TA : S_SKIP;
                S_TA:    if (cnt == CNT_W'(1)) st_n = is_rd ? S_RDATA : S_WDATA;
                S_RDATA,
                S_WDATA: if (cnt == CNT_W'(DATA_W-1)) st_n = S_IDLE;
                S_SKIP:  if (cnt == CNT_W'(SKIP_BITS-1)) st_n = S_IDLE;
                default: st_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // field capture and bit counting on sampled edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sh_q      <= '0;
            op_q      <= '0;
            phy_q     <= '0;
            reg_q     <= '0;
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (rise_i) begin
                cnt <= (st_n != st) ? '0 : cnt + CNT_W'(1);
                unique case (st)
                    S_OP: begin
                        sh_q <= {sh_q[DATA_W-2:0], bit_i};
                        if (cnt == CNT_W'(1)) op_q <= {sh_q[0], bit_i};
                    end
                    S_PHY: begin
                        sh_q <= {sh_q[DATA_W-2:0], bit_i};
                        if (cnt == CNT_W'(FIELD_W-1)) phy_q <= {sh_q[FIELD_W-2:0], bit_i};
                    end
                    S_REG: begin
                        sh_q <= {sh_q[DATA_W-2:0], bit_i};
                        if (cnt == CNT_W'(FIELD_W-1)) reg_q <= {sh_q[FIELD_W-2:0], bit_i};
                    end
                    S_TA: begin
                        if (cnt == CNT_W'(1) && is_rd) sh_q <= rd_data_i;
                    end
                    S_RDATA: sh_q <= {sh_q[DATA_W-2:0], 1'b0};
                    S_WDATA: begin
                        sh_q <= {sh_q[DATA_W-2:0], bit_i};
                        if (cnt == CNT_W'(DATA_W-1)) begin
                            wr_en_o   <= 1'b1;
                            wr_data_o <= {sh_q[DATA_W-2:0], bit_i};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // line outputs change on falling edges only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_o   <= 1'b0;
            dout_o <= 1'b0;
        end else if (fall_i) begin
            oe_o   <= (st == S_TA && cnt == CNT_W'(1) && is_rd) || (st == S_RDATA);
            dout_o <= (st == S_RDATA) ? sh_q[DATA_W-1] : 1'b0;
        end
    end

    assign addr_o  = reg_q;
    assign state_o = st;
    assign phy_o   = phy_q;
    assign op_o    = op_q;

endmodule

// File: rtl/mdio_page_bank.sv
module mdio_page_bank
    import mdio_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_PAGES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [FIELD_W-1:0] addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [DATA_W-1:0]  page_o
);

    localparam int PAGE_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int DEPTH   = 1 << FIELD_W;

    logic [DATA_W-1:0] page_q;
    logic [PAGE_W-1:0] page_sel;
    logic [DATA_W-1:0] pg_rd [NUM_PAGES];
    logic              hit_page_reg;

    assign page_sel     = page_q[PAGE_W-1:0];
    assign hit_page_reg = (addr_i == PAGE_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n)                        page_q <= '0;
        else if (wr_en_i && hit_page_reg)  page_q <= wr_data_i;
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en_i && !hit_page_reg && page_sel == PAGE_W'(p)) begin
                mem[addr_i] <= wr_data_i;
            end
        end

        assign pg_rd[p] = mem[addr_i];
    end

    assign rd_data_o = hit_page_reg ? page_q : pg_rd[page_sel];
    assign page_o    = page_q;

endmodule

// File: rtl/mdio_paged_slave.sv
module mdio_paged_slave
    import mdio_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NUM_PAGES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mdc_i,
    input  logic       mdio_i,
    input  logic [4:0] phy_addr_i,
    output logic       mdio_oe_o,
    output logic       mdio_o
);

    logic               mdc_rise, mdc_fall, bit_s;
    logic               wr_en;
    logic [FIELD_W-1:0] wr_addr;
    logic [DATA_W-1:0]  wr_data, rd_data, page_q;
    mdio_state_e        st;
    logic [FIELD_W-1:0] fr_phy;
    logic [1:0]         fr_op;

    mdc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc_i),
        .mdio_i (mdio_i),
        .rise_o (mdc_rise),
        .fall_o (mdc_fall),
        .bit_o  (bit_s)
    );

    mdio_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (mdc_rise),
        .fall_i     (mdc_fall),
        .bit_i      (bit_s),
        .phy_addr_i (phy_addr_i),
        .rd_data_i  (rd_data),
        .wr_en_o    (wr_en),
        .addr_o     (wr_addr),
        .wr_data_o  (wr_data),
        .oe_o       (mdio_oe_o),
        .dout_o     (mdio_o),
        .state_o    (st),
        .phy_o      (fr_phy),
        .op_o       (fr_op)
    );

    mdio_page_bank #(.DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (wr_addr),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .page_o    (page_q)
    );

endmodule

// File: rtl/mdio_paged_slave_chk.sv
module mdio_paged_slave_chk
    import mdio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               oe,
    input logic               dout,
    input logic [4:0]         phy_cfg,
    input mdio_state_e        st,
    input logic [FIELD_W-1:0] fr_phy,
    input logic [1:0]         fr_op,
    input logic               wr_en,
    input logic [FIELD_W-1:0] wr_addr,
    input logic [DATA_W-1:0]  page_q
);

    assert_released_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !oe);

    assert_drive_starts_in_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> (st == S_TA));

    assert_turnaround_drives_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && st == S_TA) |-> !dout);

    assert_drive_only_own_address_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> (fr_phy == phy_cfg));

    assert_page_held_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == PAGE_ADDR) |=> $stable(page_q));

    assert_commit_needs_write_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fr_op == OP_WRITE));

endmodule

bind mdio_paged_slave mdio_paged_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .oe      (mdio_oe_o),
    .dout    (mdio_o),
    .phy_cfg (phy_addr_i),
    .st      (st),
    .fr_phy  (fr_phy),
    .fr_op   (fr_op),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .page_q  (page_q)
);

// File: tb/mdio_paged_slave_tb.sv
module mdio_paged_slave_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF_BIT   = 4;
    localparam logic [4:0] MY_PHY = 5'd5;
    localparam int  NV = 10;

    // entry: op(2) phy(5) reg(5) write data(16) expected read(16)
    localparam logic [43:0] VEC [NV] = '{
        {2'b01, 5'd5, 5'd0,  16'h1234, 16'h0000},  // R2 write page 0
        {2'b01, 5'd5, 5'd5,  16'hABCD, 16'h0000},  // R2
        {2'b10, 5'd5, 5'd0,  16'h0000, 16'h1234},  // R3 read back
        {2'b01, 5'd5, 5'd31, 16'h0001, 16'h0000},  // R4 select page 1
        {2'b10, 5'd5, 5'd0,  16'h0000, 16'h0000},  // R5 page 1 is empty
        {2'b01, 5'd5, 5'd0,  16'h5555, 16'h0000},  // R5
        {2'b10, 5'd5, 5'd31, 16'h0000, 16'h0001},  // R4 read select
        {2'b01, 5'd5, 5'd31, 16'h0000, 16'h0000},  // R4 back to page 0
        {2'b10, 5'd5, 5'd0,  16'h0000, 16'h1234},  // R5 page 0 untouched
        {2'b10, 5'd5, 5'd5,  16'h0000, 16'hABCD}   // R2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdc = 1'b0;
    logic       mdio_m = 1'b1;
    logic       mdio_oe, mdio_out, line;
    int         n_tests = 0;
    int         n_fail = 0;

    assign line = mdio_oe ? mdio_out : mdio_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_paged_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdc_i      (mdc),
        .mdio_i     (line),
        .phy_addr_i (MY_PHY),
        .mdio_oe_o  (mdio_oe),
        .mdio_o     (mdio_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic b, output logic o_oe, output logic o_val);
        mdc = 1'b0;
        mdio_m = b;
        repeat (HALF_BIT) @(posedge clk);
        #2;
        o_oe  = mdio_oe;
        o_val = line;
        mdc = 1'b1;
        repeat (HALF_BIT) @(posedge clk);
        #2;
    endtask

    task automatic run_frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] wd,
                             output logic [15:0] rd, output logic pat_ok, output logic drove);
        logic o, v;
        logic rdop;
        rdop   = (op == 2'b10);
        pat_ok = 1'b1;
        drove  = 1'b0;
        rd     = '0;
        for (int i = 0; i < pre; i++) begin bit_cycle(1'b1, o, v); drove |= o; end
        bit_cycle(1'b0, o, v); drove |= o;
        bit_cycle(1'b1, o, v); drove |= o;
        for (int i = 1; i >= 0; i--) begin bit_cycle(op[i], o, v); drove |= o; end
        for (int i = 4; i >= 0; i--) begin bit_cycle(phy[i], o, v); drove |= o; end
        for (int i = 4; i >= 0; i--) begin bit_cycle(ra[i], o, v); drove |= o; end
        bit_cycle(1'b1, o, v); drove |= o;
        if (o) pat_ok = 1'b0;
        bit_cycle(rdop ? 1'b1 : 1'b0, o, v); drove |= o;
        if (!o || v) pat_ok = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            bit_cycle(rdop ? 1'b1 : wd[i], o, v);
            drove |= o;
            rd[i] = v;
            if (!o) pat_ok = 1'b0;
        end
        bit_cycle(1'b1, o, v);
        drove |= o;
        if (o) pat_ok = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] ra, output logic [15:0] rd, output logic ok);
        logic dr;
        run_frame(2, 2'b10, MY_PHY, ra, 16'h0, rd, ok, dr);
    endtask

    task automatic do_write(input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] rd;
        logic ok, dr;
        run_frame(2, 2'b01, MY_PHY, ra, wd, rd, ok, dr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic ok, dr;
        repeat (5) @(posedge clk);
        #2;
        check("R1 oe during reset", {31'd0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 oe after reset", {31'd0, mdio_oe}, 32'd0);
        do_read(5'd31, rd, ok);
        check("R1 page select zero", {16'd0, rd}, 32'd0);
        do_read(5'd7, rd, ok);
        check("R1 register zero", {16'd0, rd}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            logic [43:0] e;
            e = VEC[k];
            run_frame(3, e[43:42], e[41:37], e[36:32], e[31:16], rd, ok, dr);
            if (e[43:42] == 2'b10) begin
                check($sformatf("R2/R4/R5 vector %0d data", k), {16'd0, rd}, {16'd0, e[15:0]});
                check($sformatf("R3 vector %0d drive pattern", k), {31'd0, ok}, 32'd1);
            end else begin
                check($sformatf("R2 vector %0d write not driven", k), {31'd0, dr}, 32'd0);
            end
        end

        // R6 foreign address: write ignored, read never driven
        run_frame(2, 2'b01, 5'd6, 5'd0, 16'hFFFF, rd, ok, dr);
        check("R6 foreign write not driven", {31'd0, dr}, 32'd0);
        run_frame(2, 2'b10, 5'd6, 5'd0, 16'h0, rd, ok, dr);
        check("R6 foreign read not driven", {31'd0, dr}, 32'd0);
        do_read(5'd0, rd, ok);
        check("R6 register unchanged", {16'd0, rd}, 32'h1234);

        // R8 invalid opcodes
        run_frame(2, 2'b11, MY_PHY, 5'd0, 16'hDEAD, rd, ok, dr);
        check("R8 opcode 11 not driven", {31'd0, dr}, 32'd0);
        run_frame(2, 2'b00, MY_PHY, 5'd5, 16'hBEEF, rd, ok, dr);
        check("R8 opcode 00 not driven", {31'd0, dr}, 32'd0);
        do_read(5'd0, rd, ok);
        check("R8 reg0 unchanged", {16'd0, rd}, 32'h1234);
        do_read(5'd5, rd, ok);
        check("R8 reg5 unchanged", {16'd0, rd}, 32'hABCD);

        // R7 long and zero preambles
        run_frame(40, 2'b01, MY_PHY, 5'd9, 16'h0F0F, rd, ok, dr);
        run_frame(0, 2'b10, MY_PHY, 5'd9, 16'h0, rd, ok, dr);
        check("R7 zero preamble read", {16'd0, rd}, 32'h0F0F);
        check("R7 zero preamble pattern", {31'd0, ok}, 32'd1);

        // R4/R5 pages 2 and 3, and address 31 reached from a non-zero page
        do_write(5'd31, 16'h0003);
        do_write(5'd12, 16'h3333);
        do_write(5'd31, 16'h0002);
        do_write(5'd12, 16'h2222);
        do_read(5'd31, rd, ok);
        check("R4 select written from page 3", {16'd0, rd}, 32'h0002);
        do_write(5'd31, 16'hFFF3);
        do_read(5'd12, rd, ok);
        check("R4 low bits choose page 3", {16'd0, rd}, 32'h3333);
        do_read(5'd31, rd, ok);
        check("R4 full select readback", {16'd0, rd}, 32'hFFF3);
        do_write(5'd31, 16'h0002);
        do_read(5'd12, rd, ok);
        check("R5 page 2 separate", {16'd0, rd}, 32'h2222);
        do_write(5'd31, 16'h0000);
        do_read(5'd12, rd, ok);
        check("R5 page 0 untouched", {16'd0, rd}, 32'h0000);

        // R1 reset in mid-run clears storage and page select
        do_write(5'd31, 16'h0001);
        @(posedge clk); #2;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 oe in second reset", {31'd0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        do_read(5'd31, rd, ok);
        check("R1 page cleared by reset", {16'd0, rd}, 32'd0);
        do_read(5'd0, rd, ok);
        check("R1 storage cleared by reset", {16'd0, rd}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule